// File: doc/BRIEF.md
# Dual-Clock FIFO with Rewind

This block is a first-in first-out buffer whose write side and read side run on separate, unrelated clocks. Words of `DATA_W` bits go in on the write clock when the active-low write enable is low and the buffer has room. They come out in the same order on the read clock. The depth is `2**ADDR_W` words, and the default is kept small so that every boundary is quick to reach.

The handshake is fixed by a master reset. The level of `mode_sel` while `mrst_n` is low decides how the read side behaves:
- **Request mode** (`mode_sel` low): every word must be fetched with `ren_n`. `rd_flag` is an active-low empty flag and `wr_flag` is an active-low full flag.
- **Fall-through mode** (`mode_sel` high): the oldest word is placed on `dout` without a request. `rd_flag` low means `dout` holds valid data, and `wr_flag` low means there is room for a write.

A partial reset empties the buffer and clears `dout` but keeps the mode that is already latched. A rewind command moves the read pointer back to memory location 0, so that words already read can be read again. The rewind starts with a short setup phase, and that phase is visible on `rd_flag`.

Top module: `rtx_fifo`

## Requirements
- R1: While `mrst_n` is low (asynchronous, active low), both pointers return to location 0 and `dout` becomes 0. In request mode this gives `rd_flag`=0 and `wr_flag`=1. In fall-through mode it gives `rd_flag`=1 and `wr_flag`=0.
- R2: The level of `mode_sel` during master reset selects the mode: 0 selects request mode and 1 selects fall-through mode. Neither `mode_sel` after reset nor a partial reset changes the mode.
- R3: While `prst_n` is low (asynchronous, active low), the pointers return to 0 and `dout` becomes 0. The flags take the reset values of the mode already latched.
- R4: A word is stored on a rising `wclk` edge when `wen_n` is 0 and the buffer is not full. Once the memory holds `2**ADDR_W` unread words, the full indication is raised: `wr_flag`=0 in request mode, `wr_flag`=1 in fall-through mode. While full, further writes are dropped.
- R5: In request mode, each word, including the first, is loaded into `dout` by a rising `rclk` edge with `ren_n`=0. Words come out in write order. `dout` holds its value while `ren_n` is 1. `rd_flag` falls in the cycle the last stored word is taken.
- R6: A read request while the buffer is empty does not move the read pointer and leaves `dout` unchanged.
- R7: In fall-through mode, the first word written into an empty buffer appears on `dout` with `rd_flag`=0 within three `rclk` edges after the pointer crosses, and no read request is needed. Each `rclk` edge with `ren_n`=0 then replaces it with the next word, or raises `rd_flag` if no word is left.
- R8: `rt_n`=0 sampled on a rising `rclk` edge while `ren_n`=1 and no rewind is pending starts a rewind. The read pointer becomes 0 and a setup phase of `RT_SETUP` read cycles follows. In request mode `rd_flag` is held at 0 during setup. It then rises, and reads restart from location 0, one `ren_n` per word.
- R9: During rewind setup in fall-through mode, `rd_flag` is 1. When setup ends, the word at location 0 is placed on `dout` and `rd_flag` falls, with no read request.
- R10: Pointers cross between the clock domains as Gray codes through two-flop synchronizers. The code changes by at most one bit per edge, except at reset or rewind. Full is computed on the write clock and empty on the read clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, asynchronous, active low; latches the mode |
| prst_n | input | 1 | Partial reset, asynchronous, active low; keeps the mode |
| mode_sel | input | 1 | Mode select, sampled during master reset (1 = fall-through) |
| wen_n | input | 1 | Write enable, active low |
| din | input | DATA_W | Write data |
| ren_n | input | 1 | Read enable, active low |
| rt_n | input | 1 | Rewind request, active low |
| dout | output | DATA_W | Output data register |
| rd_flag | output | 1 | Empty flag (active low) in request mode; output-not-ready in fall-through mode |
| wr_flag | output | 1 | Full flag (active low) in request mode; input-not-ready in fall-through mode |

## Verification
The hardest state to reach from the ports is a rewind that lands while the read side still holds data. In fall-through mode this means a word already sits in the output register and the memory is partly drained. The stimulus fills the buffer, consumes part of it with single read requests, and only then pulses `rt_n` with both enables idle. It samples `rd_flag` in the first setup cycle, then checks that location 0 reappears without a request. A buffer held full behind a preloaded fall-through output register is reached the same way: the first word is given time to fall through, then a burst of writes follows, including one that must be dropped.

// File: rtl/rtx_fifo_pkg.sv
// Package: shared types for the dual-clock rewind FIFO.
// Assumes: nothing beyond IEEE 1800-2017.
package rtx_fifo_pkg;
    // Read-side handshake selected at master reset.
    typedef enum logic {
        MODE_REQ  = 1'b0,
        MODE_FALL = 1'b1
    } fifo_mode_e;
endpackage

// File: rtl/rtx_fifo_sync.sv
// Two-flop synchronizer for a Gray-coded pointer.
// Assumes: the input changes by at most one bit per source edge.
module rtx_fifo_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two register stages into the destination clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/rtx_fifo_mem.sv
// Storage array: written on the write clock, read combinationally by address.
// Assumes: the read address is only used once the written word has crossed over.
module rtx_fifo_mem #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 3
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    // Store one word per enabled write edge.
    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/rtx_fifo_wr.sv
// Write side: pointer, full detection and the input flag.
// Assumes: ADDR_W >= 2; rptr_gs is the read pointer already synchronized to wclk.
module rtx_fifo_wr
    import rtx_fifo_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic            wclk,
    input  logic            rst_n,
    input  logic            mrst_n,
    input  logic            mode_sel,
    input  logic            wen_n,
    input  logic [ADDR_W:0] rptr_gs,
    output logic [ADDR_W:0] wptr_g,
    output logic [ADDR_W-1:0] waddr,
    output logic            we,
    output logic            wr_flag
);
    fifo_mode_e      mode_q;
    logic [ADDR_W:0] wbin;
    logic [ADDR_W:0] wbin_nx;
    logic            full;

    // Latch the handshake mode while the master reset is held.
    always_ff @(posedge wclk or negedge mrst_n) begin
        if (!mrst_n) begin
            mode_q <= fifo_mode_e'(mode_sel);
        end
    end

    assign full    = (wptr_g == {~rptr_gs[ADDR_W:ADDR_W-1], rptr_gs[ADDR_W-2:0]});
    assign we      = !wen_n && !full;
    assign wbin_nx = wbin + 1'b1;
    assign waddr   = wbin[ADDR_W-1:0];
    assign wr_flag = (mode_q == MODE_FALL) ? full : !full;

    // Advance binary and Gray write pointers on each accepted write.
    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) begin
            wbin   <= '0;
            wptr_g <= '0;
        end else if (we) begin
            wbin   <= wbin_nx;
            wptr_g <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (!rst_n)
        full |=> $stable(wbin)); // R4
    AST_WGRAY_STEP: assert property (@(posedge wclk) disable iff (!rst_n)
        $onehot0(wptr_g ^ $past(wptr_g))); // R10
endmodule

// File: rtl/rtx_fifo_rd.sv
// Read side: pointer, empty detection, output register, fall-through
// preload and the rewind sequencer.
// Assumes: wptr_gs is the write pointer synchronized to rclk; a rewind is
// only issued while no write is in progress and before the write pointer wraps.
module rtx_fifo_rd
    import rtx_fifo_pkg::*;
#(
    parameter int DATA_W   = 18,
    parameter int ADDR_W   = 3,
    parameter int RT_SETUP = 2
) (
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              mrst_n,
    input  logic              mode_sel,
    input  logic              ren_n,
    input  logic              rt_n,
    input  logic [ADDR_W:0]   wptr_gs,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W:0]   rptr_g,
    output logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] dout,
    output logic              rd_flag
);
    localparam int CW = $clog2(RT_SETUP + 1);

    fifo_mode_e      mode_q;
    logic [ADDR_W:0] rbin;
    logic [ADDR_W:0] rbin_nx;
    logic [ADDR_W:0] wbin_s;
    logic [CW-1:0]   rt_cnt;
    logic            ovalid;
    logic            mem_empty;
    logic            rt_busy;
    logic            rt_start;
    logic            take;
    logic            fall;

    // Convert a Gray pointer back to binary.
    function automatic logic [ADDR_W:0] g2b(input logic [ADDR_W:0] g);
        logic [ADDR_W:0] b;
        b[ADDR_W] = g[ADDR_W];
        for (int i = ADDR_W - 1; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    // Latch the handshake mode while the master reset is held.
    always_ff @(posedge rclk or negedge mrst_n) begin
        if (!mrst_n) begin
            mode_q <= fifo_mode_e'(mode_sel);
        end
    end

    assign fall      = (mode_q == MODE_FALL);
    assign wbin_s    = g2b(wptr_gs);
    assign mem_empty = (rbin == wbin_s);
    assign rt_busy   = (rt_cnt != '0);
    assign rt_start  = !rt_n && ren_n && !rt_busy;
    assign rbin_nx   = rbin + 1'b1;
    assign raddr     = rbin[ADDR_W-1:0];

    // Decide whether a stored word moves into the output register this cycle.
    always_comb begin
        if (rt_busy || mem_empty) begin
            take = 1'b0;
        end else if (fall) begin
            take = !ovalid || !ren_n;
        end else begin
            take = !ren_n;
        end
    end

    // Pointer, output register and rewind sequencing.
    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) begin
            rbin   <= '0;
            rptr_g <= '0;
            dout   <= '0;
            ovalid <= 1'b0;
            rt_cnt <= '0;
        end else if (rt_start) begin
            rbin   <= '0;
            rptr_g <= '0;
            ovalid <= 1'b0;
            rt_cnt <= CW'(RT_SETUP);
        end else begin
            if (rt_busy) begin
                rt_cnt <= rt_cnt - 1'b1;
            end
            if (take) begin
                rbin   <= rbin_nx;
                rptr_g <= rbin_nx ^ (rbin_nx >> 1);
                dout   <= rdata;
                ovalid <= 1'b1;
            end else if (!ren_n) begin
                ovalid <= 1'b0;
            end
        end
    end

    assign rd_flag = fall ? !ovalid : (!rt_busy && !mem_empty);

    AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (!rst_n)
        (mem_empty && !rt_start) |=> $stable(rbin)); // R6
    AST_REQ_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
        (!fall && ren_n && !rt_start) |=> $stable(dout)); // R5
    AST_RT_REWIND: assert property (@(posedge rclk) disable iff (!rst_n)
        rt_start |=> (rbin == '0)); // R8
    AST_RT_REQ_FLAG: assert property (@(posedge rclk) disable iff (!rst_n)
        (rt_busy && !fall) |-> !rd_flag); // R8
    AST_RT_FALL_FLAG: assert property (@(posedge rclk) disable iff (!rst_n)
        (rt_busy && fall) |-> rd_flag); // R9
    AST_RGRAY_STEP: assert property (@(posedge rclk) disable iff (!rst_n)
        !$past(rt_start) |-> $onehot0(rptr_g ^ $past(rptr_g))); // R10
endmodule

// File: rtl/rtx_fifo.sv
// Top: dual-clock FIFO with mode latched at master reset, partial reset and
// rewind. Joins the storage, both pointer sides and the pointer synchronizers.
// Assumes: resets are held across at least one edge of each clock.
module rtx_fifo #(
    parameter int DATA_W   = 18,
    parameter int ADDR_W   = 3,
    parameter int RT_SETUP = 2
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              mode_sel,
    input  logic              wen_n,
    input  logic [DATA_W-1:0] din,
    input  logic              ren_n,
    input  logic              rt_n,
    output logic [DATA_W-1:0] dout,
    output logic              rd_flag,
    output logic              wr_flag
);
    localparam int PW = ADDR_W + 1;

    logic              rst_n;
    logic [PW-1:0]     wptr_g, wptr_gs, rptr_g, rptr_gs;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [DATA_W-1:0] rdata;
    logic              we;

    assign rst_n = mrst_n & prst_n;

    rtx_fifo_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk(wclk), .we(we), .waddr(waddr), .wdata(din),
        .raddr(raddr), .rdata(rdata)
    );

    rtx_fifo_wr #(.ADDR_W(ADDR_W)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .mrst_n(mrst_n), .mode_sel(mode_sel),
        .wen_n(wen_n), .rptr_gs(rptr_gs), .wptr_g(wptr_g), .waddr(waddr),
        .we(we), .wr_flag(wr_flag)
    );

    rtx_fifo_rd #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RT_SETUP(RT_SETUP)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .mrst_n(mrst_n), .mode_sel(mode_sel),
        .ren_n(ren_n), .rt_n(rt_n), .wptr_gs(wptr_gs), .rdata(rdata),
        .rptr_g(rptr_g), .raddr(raddr), .dout(dout), .rd_flag(rd_flag)
    );

    rtx_fifo_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wptr_g), .q(wptr_gs)
    );

    rtx_fifo_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rptr_g), .q(rptr_gs)
    );
endmodule

// File: tb/rtx_fifo_tb.sv
// Bench: fills, drains and rewinds an 8-deep FIFO in both modes.
module rtx_fifo_tb;
    localparam int DW = 18;
    localparam int AW = 3;
    localparam int DEPTH = 1 << AW;

    logic wclk = 1'b0, rclk = 1'b0;
    logic mrst_n = 1'b0, prst_n = 1'b1, mode_sel = 1'b0;
    logic wen_n = 1'b1, ren_n = 1'b1, rt_n = 1'b1;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic rd_flag, wr_flag;
    int tests = 0, fails = 0;

    always #2 wclk = ~wclk;
    always #3 rclk = ~rclk;

    rtx_fifo #(.DATA_W(DW), .ADDR_W(AW), .RT_SETUP(2)) u_dut (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .mode_sel(mode_sel), .wen_n(wen_n), .din(din), .ren_n(ren_n),
        .rt_n(rt_n), .dout(dout), .rd_flag(rd_flag), .wr_flag(wr_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (6) @(negedge wclk);
    endtask

    task automatic mreset(input logic m);
        @(negedge wclk);
        mode_sel = m;
        mrst_n = 1'b0;
        repeat (3) @(negedge rclk);
        mrst_n = 1'b1;
        mode_sel = ~m;   // later level must not matter (R2)
        settle();
    endtask

    task automatic preset();
        @(negedge wclk);
        prst_n = 1'b0;
        repeat (3) @(negedge rclk);
        prst_n = 1'b1;
        settle();
    endtask

    task automatic wr(input logic [DW-1:0] v);
        @(negedge wclk);
        wen_n = 1'b0;
        din = v;
        @(negedge wclk);
        wen_n = 1'b1;
    endtask

    // One read request; leaves the sampling point at the following negedge.
    task automatic rd();
        @(negedge rclk);
        ren_n = 1'b0;
        @(negedge rclk);
        ren_n = 1'b1;
    endtask

    task automatic rewind();
        @(negedge rclk);
        rt_n = 1'b0;
        @(negedge rclk);
        rt_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge wclk);
        fails++;
        tests++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // ---------------- request mode ----------------
        mreset(1'b0);
        chk("R1 req rd_flag after master reset", 32'(rd_flag), 0);
        chk("R1 req wr_flag after master reset", 32'(wr_flag), 1);
        chk("R1 dout after master reset", 32'(dout), 0);

        for (int i = 0; i < DEPTH; i++) wr(DW'(18'h100 + i));
        wr(18'h3FFFF);    // dropped while full (R4)
        settle();
        chk("R4 req full flag", 32'(wr_flag), 0);
        chk("R5 req not empty before reads", 32'(rd_flag), 1);
        chk("R5 dout waits for request", 32'(dout), 0);

        for (int i = 0; i < DEPTH; i++) begin
            rd();
            chk("R5 req read order", 32'(dout), 32'h100 + i);
        end
        chk("R5 empty after last word", 32'(rd_flag), 0);
        settle();
        chk("R4 dropped write not stored", 32'(rd_flag), 0);
        chk("R4 room after drain", 32'(wr_flag), 1);

        for (int k = 0; k < 3; k++) rd();
        chk("R6 read while empty holds dout", 32'(dout), 32'h100 + DEPTH - 1);
        chk("R6 read while empty keeps empty", 32'(rd_flag), 0);

        rewind();
        chk("R8 req flag low in setup", 32'(rd_flag), 0);
        settle();
        chk("R8 req flag high after setup", 32'(rd_flag), 1);
        chk("R8 dout held until request", 32'(dout), 32'h100 + DEPTH - 1);
        for (int i = 0; i < DEPTH; i++) begin
            rd();
            chk("R8 reread order", 32'(dout), 32'h100 + i);
        end
        chk("R8 empty after reread", 32'(rd_flag), 0);

        preset();
        chk("R3 dout cleared by partial reset", 32'(dout), 0);
        chk("R3 req rd_flag after partial reset", 32'(rd_flag), 0);
        chk("R3 req wr_flag after partial reset", 32'(wr_flag), 1);
        wr(18'h155);
        settle();
        chk("R2 mode kept: word not pushed out", 32'(dout), 0);
        chk("R2 mode kept: not-empty flag", 32'(rd_flag), 1);
        rd();
        chk("R5 read after partial reset", 32'(dout), 32'h155);

        // ---------------- fall-through mode ----------------
        mreset(1'b1);
        chk("R1 fall rd_flag after master reset", 32'(rd_flag), 1);
        chk("R1 fall wr_flag after master reset", 32'(wr_flag), 0);
        chk("R1 fall dout after master reset", 32'(dout), 0);

        wr(18'h2A5);
        chk("R7 not ready before crossing", 32'(rd_flag), 1);
        repeat (5) @(negedge rclk);
        chk("R7 first word falls through", 32'(dout), 32'h2A5);
        chk("R7 ready flag low", 32'(rd_flag), 0);

        for (int i = 0; i < DEPTH; i++) wr(DW'(18'h200 + i));
        wr(18'h3FFFF);    // dropped (R4)
        settle();
        chk("R4 fall full flag", 32'(wr_flag), 1);
        chk("R7 head held without request", 32'(dout), 32'h2A5);
        for (int i = 0; i < DEPTH; i++) begin
            rd();
            chk("R7 fall read order", 32'(dout), 32'h200 + i);
        end
        rd();
        chk("R7 not ready after last word", 32'(rd_flag), 1);
        chk("R4 fall room after drain", 32'(wr_flag), 0);

        preset();
        chk("R3 fall mode kept", 32'(rd_flag), 1);
        chk("R3 fall dout cleared", 32'(dout), 0);

        wr(18'h011);
        wr(18'h022);
        wr(18'h033);
        settle();
        chk("R9 head before rewind", 32'(dout), 32'h011);
        rd();
        chk("R9 second word before rewind", 32'(dout), 32'h022);
        rewind();
        chk("R9 not ready in setup", 32'(rd_flag), 1);
        settle();
        chk("R9 location 0 presented", 32'(dout), 32'h011);
        chk("R9 ready after setup", 32'(rd_flag), 0);
        rd();
        chk("R9 continues after rewind", 32'(dout), 32'h022);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule